// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block keeps the instruction fetch address of a small 16-bit processor and picks the next one every clock. In each cycle it is given three inputs. The first is the instruction word that was fetched from the current address. The second is the value read from the register named in the instruction's first register field. The third is the compare flag. From these it chooses between four outcomes:

- plain sequential advance;
- an absolute jump to the register value;
- an unconditional jump relative to the current address;
- a relative branch that is taken only when the compare flag is set.

The next address is registered. When the flow is redirected, a one-cycle `taken` pulse is produced in the same cycle that the new address appears. The register file, the instruction memory and the compare logic lie outside this block.

The instruction word is split into three fields. Bits 15:12 hold the opcode. Bit 11 is a mode bit. Bits 10:0 hold a two's-complement offset. Addresses count words. Relative offsets are added to the address of the control instruction itself, and all address arithmetic wraps modulo 2^16.

Top module: `pcu_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `fetch_addr` = 0 and `taken` = 0.
- R2: An instruction whose opcode (bits 15:12) is neither 4'b0111 nor 4'b1000, including 4'b0000, advances `fetch_addr` by 1 and leaves `taken` low, whatever `reg_val` and `cmp_flag` hold.
- R3: Opcode 4'b0111 with bit 11 = 0 loads `fetch_addr` with `reg_val` and raises `taken` for one cycle.
- R4: Opcode 4'b0111 with bit 11 = 1 sets `fetch_addr` to the current address plus bits 10:0 sign-extended to 16 bits, and raises `taken`.
- R5: Opcode 4'b1000 with `cmp_flag` = 1 sets `fetch_addr` to the current address plus bits 10:0 sign-extended, and raises `taken`. Bit 11 has no effect.
- R6: Opcode 4'b1000 with `cmp_flag` = 0 advances `fetch_addr` by 1 and leaves `taken` low.
- R7: A branch is decided only by the value `cmp_flag` has in the same cycle as the branch word. The flag's value in earlier cycles has no effect, and there is no delay slot.
- R8: Sequential and relative address arithmetic wraps modulo 2^16, both past 16'hFFFF and below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word fetched from `fetch_addr` |
| reg_val | input | 16 | Value of the register selected by the instruction |
| cmp_flag | input | 1 | Compare flag from the preceding compare |
| fetch_addr | output | 16 | Current program counter / fetch address |
| taken | output | 1 | High for one cycle after each redirect |

## Verification
The hardest situations to reach from the ports are the edges of the address space. One is a relative offset of -1024 or +1023 applied near address 0 or near 16'hFFFF, so that the sum wraps. The other is the flag changing on exactly the cycle a branch arrives. Random stimulus alone rarely lands there. The bench therefore first uses an absolute register jump to place the program counter next to each boundary, then issues relative jumps and branches at the extreme offsets. It also toggles `cmp_flag` between a compare-like word and the branch that follows it. Random phases bias the opcode toward the two control opcodes so that redirects happen back to back.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_JUMP   = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b1000;

    // Which source feeds the program counter next cycle.
    typedef enum logic [1:0] {
        SEL_SEQ = 2'd0,
        SEL_ABS = 2'd1,
        SEL_REL = 2'd2
    } next_sel_e;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             mode_bit,
    input  logic             cmp_flag,
    output next_sel_e        sel,
    output logic             redirect
);

    always_comb begin
        sel      = SEL_SEQ;
        redirect = 1'b0;
        unique case (opcode)
            OPC_JUMP: begin
                sel      = mode_bit ? SEL_REL : SEL_ABS;
                redirect = 1'b1;
            end
            OPC_BRANCH: begin
                if (cmp_flag) begin
                    sel      = SEL_REL;
                    redirect = 1'b1;
                end
            end
            default: begin
                sel      = SEL_SEQ;
                redirect = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
module pcu_target
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 11
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [OFF_W-1:0]  offset,
    input  next_sel_e         sel,
    output logic [ADDR_W-1:0] next_pc
);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] rel_addr;

    generate
        if (OFF_W < ADDR_W) begin : g_sext
            assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    assign seq_addr = pc + ADDR_W'(1);
    assign rel_addr = pc + off_ext;

    always_comb begin
        unique case (sel)
            SEL_ABS: next_pc = abs_addr;
            SEL_REL: next_pc = rel_addr;
            default: next_pc = seq_addr;
        endcase
    end

endmodule

// File: rtl/pcu_branch_unit.sv
module pcu_branch_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16,
    parameter int OFF_W   = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  reg_val,
    input  logic               cmp_flag,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               taken
);

    localparam int MODE_POS = INSTR_W - OPC_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              taken;
    } pcu_state_t;

    pcu_state_t        state_d;
    pcu_state_t        state_q;
    next_sel_e         sel;
    logic              redirect;
    logic [ADDR_W-1:0] target;

    pcu_decode u_decode (
        .opcode   (instr[INSTR_W-1 -: OPC_W]),
        .mode_bit (instr[MODE_POS]),
        .cmp_flag (cmp_flag),
        .sel      (sel),
        .redirect (redirect)
    );

    pcu_target #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_target (
        .pc       (state_q.pc),
        .abs_addr (reg_val),
        .offset   (instr[OFF_W-1:0]),
        .sel      (sel),
        .next_pc  (target)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc    = '0;
            state_d.taken = 1'b0;
        end else begin
            state_d.pc    = target;
            state_d.taken = redirect;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign fetch_addr = state_q.pc;
    assign taken      = state_q.taken;

endmodule

// File: rtl/pcu_branch_unit_checker.sv
module pcu_branch_unit_checker #(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16,
    parameter int OFF_W   = 11
) (
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  reg_val,
    input logic               cmp_flag,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic               taken
);

    logic [3:0]        opc;
    logic              mode;
    logic [ADDR_W-1:0] off;
    logic              is_ctl;

    assign opc    = instr[INSTR_W-1 -: 4];
    assign mode   = instr[INSTR_W-5];
    assign off    = {{(ADDR_W-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};
    assign is_ctl = (opc == 4'b0111) || (opc == 4'b1000);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0 && !taken));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        !is_ctl |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1) && !taken));

    assert_abs_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (opc == 4'b0111 && !mode) |=> (fetch_addr == $past(reg_val) && taken));

    assert_rel_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (opc == 4'b0111 && mode) |=>
            (fetch_addr == ADDR_W'($past(fetch_addr) + $past(off)) && taken));

    assert_branch_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (opc == 4'b1000 && cmp_flag) |=>
            (fetch_addr == ADDR_W'($past(fetch_addr) + $past(off)) && taken));

    assert_branch_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (opc == 4'b1000 && !cmp_flag) |=>
            (fetch_addr == ADDR_W'($past(fetch_addr) + 1) && !taken));

    // R7: a taken pulse always stems from a control word in the prior cycle
    assert_taken_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && $rose(taken)) |-> $past(is_ctl));

endmodule

bind pcu_branch_unit pcu_branch_unit_checker #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W),
    .OFF_W   (OFF_W)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .instr      (instr),
    .reg_val    (reg_val),
    .cmp_flag   (cmp_flag),
    .fetch_addr (fetch_addr),
    .taken      (taken)
);

// File: tb/pcu_branch_unit_test.sv
`timescale 1ns/1ps
module pcu_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic [15:0] reg_val = '0;
    logic        cmp_flag = 1'b0;
    logic [15:0] fetch_addr;
    logic        taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model_pc = '0;

    always #2 clk = ~clk;

    pcu_branch_unit uut (
        .clk        (clk),
        .rst        (rst),
        .instr      (instr),
        .reg_val    (reg_val),
        .cmp_flag   (cmp_flag),
        .fetch_addr (fetch_addr),
        .taken      (taken)
    );

    function automatic logic [15:0] sext11(input logic [15:0] w);
        return {{5{w[10]}}, w[10:0]};
    endfunction

    function automatic logic [15:0] exp_pc(input logic [15:0] pc, input logic [15:0] w,
                                           input logic [15:0] r, input logic f);
        if (w[15:12] == 4'b0111) return w[11] ? pc + sext11(w) : r;
        if (w[15:12] == 4'b1000 && f) return pc + sext11(w);
        return pc + 16'd1;
    endfunction

    function automatic logic exp_taken(input logic [15:0] w, input logic f);
        return (w[15:12] == 4'b0111) || (w[15:12] == 4'b1000 && f);
    endfunction

    function automatic string tag_of(input logic [15:0] w, input logic f);
        if (w[15:12] == 4'b0111) return w[11] ? "R4" : "R3";
        if (w[15:12] == 4'b1000) return f ? "R5" : "R6";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [15:0] ea, input logic et);
        checks++;
        if (fetch_addr !== ea || taken !== et) begin
            errors++;
            $display("FAIL %s: fetch_addr=%h taken=%b expected fetch_addr=%h taken=%b",
                     tag, fetch_addr, taken, ea, et);
        end
    endtask

    // Present one word for one cycle and check the result after the edge.
    task automatic step(input logic [15:0] w, input logic [15:0] r, input logic f,
                        input string tag);
        logic [15:0] ea;
        logic        et;
        string       t;
        instr = w; reg_val = r; cmp_flag = f;
        ea = exp_pc(model_pc, w, r, f);
        et = exp_taken(w, f);
        t  = (tag == "") ? tag_of(w, f) : tag;
        @(negedge clk);
        check(t, ea, et);
        model_pc = ea;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst = 1'b0;
        model_pc = '0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2: nop and arithmetic words, varied reg/flag
        step(16'h0000, 16'hBEEF, 1'b1, "R2");
        step(16'h1234, 16'h0000, 1'b0, "R2");
        step(16'hC005, 16'h7777, 1'b1, "R2");
        // R3: absolute jump
        step(16'h7000, 16'h1234, 1'b0, "R3");
        step(16'h0000, 16'h0000, 1'b0, "R2");
        // R4: relative jumps at both extremes
        step(16'h7BFF, 16'h0000, 1'b0, "R4");
        step(16'h7C00, 16'h0000, 1'b1, "R4");
        // R5: taken branch, bit 11 set and clear
        step(16'h8805, 16'h0000, 1'b1, "R5");
        step(16'h8005, 16'h0000, 1'b1, "R5");
        step(16'h87FF, 16'h0000, 1'b1, "R5");
        // R6: untaken branch
        step(16'h8FFF, 16'hFFFF, 1'b0, "R6");
        // R7: flag high on a prior word, low on the branch; then the reverse
        step(16'hC000, 16'h0000, 1'b1, "R7");
        step(16'h8010, 16'h0000, 1'b0, "R7");
        step(16'hC000, 16'h0000, 1'b0, "R7");
        step(16'h8010, 16'h0000, 1'b1, "R7");
        // R8: wrap past FFFF sequentially and relatively
        step(16'h7000, 16'hFFFF, 1'b0, "R3");
        step(16'h0000, 16'h0000, 1'b0, "R8");
        step(16'h7000, 16'hFFFE, 1'b0, "R3");
        step(16'h7BFF, 16'h0000, 1'b0, "R8");
        step(16'h7000, 16'h0003, 1'b0, "R3");
        step(16'h7C00, 16'h0000, 1'b0, "R8");
        step(16'h8FF0, 16'h0000, 1'b1, "R8");
        // R1: reset in the middle of a run
        do_reset();

        // random phase, biased toward control opcodes
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] w;
            int          k;
            w = 16'($urandom);
            k = $urandom_range(0, 9);
            if (k < 3)      w[15:12] = 4'b0111;
            else if (k < 6) w[15:12] = 4'b1000;
            step(w, 16'($urandom), 1'($urandom), "");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : seed
        int unused_seed;
        unused_seed = $urandom(32'd1357);
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule